// File: doc/BRIEF.md
# Execute-Indirect Chain Controller

This block carries out an "execute the word at an address" opcode for a small instruction sequencer. When the decode stage offers an execute instruction, the block reads the word at that instruction's effective address. If the word read is itself an execute opcode, the block follows that word's effective address in turn. It keeps doing so, to any depth, until it reads a word with any other opcode. That word is the subject instruction, and it is handed to the normal execution path exactly as if it had been fetched directly.

During the chain the block holds the address of the first execute instruction and never changes the sequential instruction address. When the subject completes, the block either tells the fetch sequencer to continue at that first address plus one, or stays silent when the subject supplies its own next address (a taken branch, or a load or exchange of the status word). An interrupt seen at any fetch response of the chain, or before the subject finishes, asks for a restart at the first execute instruction. A trap at any point reports that same first address. While the chain runs, `busy` tells the fetch sequencer to hold.

Top module: `exec_chain_ctrl`

## Requirements
- R1: After reset `busy`, `mem_req`, `subj_valid`, `resume_valid`, `restart_valid` and `trap_valid` are all low.
- R2: In the idle state, `start_valid` with `start_is_exec` high starts a chain: one cycle later `busy` and `mem_req` are high and `mem_addr` equals `start_ea`. A start with `start_is_exec` low, or any start while `busy` is high, changes nothing.
- R3: A fetched word whose opcode field (bits DW-1 down to DW-OPW, value EXEC_OP, default 4'hA in bits 15:12) marks an execute makes the next request use that word's address field (bits AW-1:0); this repeats for any chain depth, and `mem_addr` holds steady while a response is awaited.
- R4: The first fetched word whose opcode field differs from EXEC_OP is presented on `subj_word` with a one-cycle `subj_valid` pulse in the cycle after its `mem_rvalid`; `busy` stays high until the subject ends.
- R5: `subj_done` with neither `subj_branch_taken` nor `subj_status_load` gives a one-cycle `resume_valid` pulse with `evt_pc` equal to the first execute's address plus one, modulo 2^AW, and returns the block to idle.
- R6: `subj_done` with `subj_branch_taken` or `subj_status_load` high returns the block to idle with no `resume_valid`, `restart_valid` or `trap_valid` pulse.
- R7: `irq_pend` high at a fetch response, or while the subject is outstanding, gives a one-cycle `restart_valid` pulse with `evt_pc` equal to the first execute's address, dispatches no subject, and returns to idle; it takes priority over `subj_done`.
- R8: `trap_in` high in any cycle while `busy` gives a one-cycle `trap_valid` pulse with `evt_pc` equal to the first execute's address and returns to idle; it takes priority over `irq_pend`, `mem_rvalid` and `subj_done`.
- R9: The address reported on `evt_pc` is the first execute's address whatever the chain depth.
- R10: At most one of `subj_valid`, `resume_valid`, `restart_valid` and `trap_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Decoded instruction offered |
| start_is_exec | input | 1 | Offered instruction is an execute |
| start_pc | input | AW | Address of the offered instruction |
| start_ea | input | AW | Effective address of the offered instruction |
| mem_req | output | 1 | Read request, held until the response |
| mem_addr | output | AW | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read response word |
| irq_pend | input | 1 | Interrupt activation pending |
| trap_in | input | 1 | Trap condition raised |
| subj_done | input | 1 | Subject instruction completed |
| subj_branch_taken | input | 1 | Subject was a branch whose condition was met |
| subj_status_load | input | 1 | Subject loaded or exchanged the status word |
| busy | output | 1 | Chain or subject in progress; fetch must hold |
| subj_valid | output | 1 | Subject word dispatch pulse |
| subj_word | output | DW | Subject instruction word |
| resume_valid | output | 1 | Continue sequentially at `evt_pc` |
| restart_valid | output | 1 | Service the interrupt, then restart at `evt_pc` |
| trap_valid | output | 1 | Trap taken; saved address is `evt_pc` |
| evt_pc | output | AW | Address carried by the event pulses |

## Verification
Every result of this block is registered: a chain's first request appears the cycle after the start is accepted, and each event pulse appears in the cycle after the edge that sampled its cause. The bench memory answers one cycle after a request and drops its response the cycle after, so the i-th fetch of a chain is consumed exactly 2·i edges after the start edge and the subject is dispatched after 2·(depth+1) edges. The bench counts edges from the start edge, drives causes only before the edge it intends, and samples on the following falling edge, so each check looks at exactly the cycle in which the result is due.

// File: rtl/exec_chain_pkg.sv
package exec_chain_pkg;

    typedef enum logic [1:0] {
        XC_IDLE  = 2'd0,
        XC_FETCH = 2'd1,
        XC_SUBJ  = 2'd2
    } xc_state_e;

endpackage

// File: rtl/exec_word_decode.sv
module exec_word_decode #(
    parameter int          DW      = 16,
    parameter int          AW      = 12,
    parameter int          OPW     = 4,
    parameter logic [OPW-1:0] EXEC_OP = 4'hA
) (
    input  logic [DW-1:0] word,
    output logic          is_exec,
    output logic [AW-1:0] ea
);
    localparam int OP_LSB = DW - OPW;

    logic [OPW-1:0] opcode;

    always_comb begin
        opcode  = word[DW-1:OP_LSB];
        is_exec = (opcode == EXEC_OP);
        ea      = word[AW-1:0];
    end

endmodule

// File: rtl/exec_chain_fsm.sv
module exec_chain_fsm
    import exec_chain_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic          start_is_exec,
    input  logic [AW-1:0] start_pc,
    input  logic [AW-1:0] start_ea,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          word_is_exec,
    input  logic [AW-1:0] word_ea,
    input  logic          irq_pend,
    input  logic          trap_in,
    input  logic          subj_done,
    input  logic          subj_branch_taken,
    input  logic          subj_status_load,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          subj_valid,
    output logic [DW-1:0] subj_word,
    output logic          resume_valid,
    output logic          restart_valid,
    output logic          trap_valid,
    output logic [AW-1:0] evt_pc
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        xc_state_e     state;
        logic [AW-1:0] origin;
        logic [AW-1:0] addr;
        logic [DW-1:0] word;
        logic [AW-1:0] evt_pc;
        logic          subj_v;
        logic          resume_v;
        logic          restart_v;
        logic          trap_v;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d           = r_q;
        r_d.subj_v    = 1'b0;
        r_d.resume_v  = 1'b0;
        r_d.restart_v = 1'b0;
        r_d.trap_v    = 1'b0;
        unique case (r_q.state)
            XC_IDLE: begin
                if (start_valid && start_is_exec) begin
                    r_d.state  = XC_FETCH;
                    r_d.origin = start_pc;
                    r_d.addr   = start_ea;
                end
            end
            XC_FETCH: begin
                if (trap_in) begin
                    r_d.trap_v = 1'b1;
                    r_d.evt_pc = r_q.origin;
                    r_d.state  = XC_IDLE;
                end else if (mem_rvalid) begin
                    if (irq_pend) begin
                        r_d.restart_v = 1'b1;
                        r_d.evt_pc    = r_q.origin;
                        r_d.state     = XC_IDLE;
                    end else if (word_is_exec) begin
                        r_d.addr = word_ea;
                    end else begin
                        r_d.subj_v = 1'b1;
                        r_d.word   = mem_rdata;
                        r_d.state  = XC_SUBJ;
                    end
                end
            end
            XC_SUBJ: begin
                if (trap_in) begin
                    r_d.trap_v = 1'b1;
                    r_d.evt_pc = r_q.origin;
                    r_d.state  = XC_IDLE;
                end else if (irq_pend) begin
                    r_d.restart_v = 1'b1;
                    r_d.evt_pc    = r_q.origin;
                    r_d.state     = XC_IDLE;
                end else if (subj_done) begin
                    if (!(subj_branch_taken || subj_status_load)) begin
                        r_d.resume_v = 1'b1;
                        r_d.evt_pc   = r_q.origin + ONE;
                    end
                    r_d.state = XC_IDLE;
                end
            end
            default: r_d.state = XC_IDLE;
        endcase
        if (r_d.state == XC_IDLE) begin
            r_d.origin = '0;
            r_d.addr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy          = (r_q.state != XC_IDLE);
        mem_req       = (r_q.state == XC_FETCH);
        mem_addr      = r_q.addr;
        subj_valid    = r_q.subj_v;
        subj_word     = r_q.word;
        resume_valid  = r_q.resume_v;
        restart_valid = r_q.restart_v;
        trap_valid    = r_q.trap_v;
        evt_pc        = r_q.evt_pc;
    end

    // R3: request address holds while a response is awaited
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && !trap_in) |=> $stable(mem_addr));

    // R9: the first execute's address is kept for the whole chain
    a_r9_origin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != XC_IDLE) |=> (r_q.state == XC_IDLE || $stable(r_q.origin)));

    // R4: a subject is only dispatched after a fetch response
    a_r4_subj_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        subj_valid |-> $past(mem_rvalid && mem_req));

    // R8: a reported trap leaves the block idle
    a_r8_trap_idles: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !busy);

    // R10: event pulses are mutually exclusive
    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({subj_valid, resume_valid, restart_valid, trap_valid}));

    // R2: no chain starts without a start request in the idle state
    a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start_valid && start_is_exec)) |=> !busy);

endmodule

// File: rtl/exec_chain_ctrl.sv
module exec_chain_ctrl #(
    parameter int             DW      = 16,
    parameter int             AW      = 12,
    parameter int             OPW     = 4,
    parameter logic [OPW-1:0] EXEC_OP = 4'hA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic          start_is_exec,
    input  logic [AW-1:0] start_pc,
    input  logic [AW-1:0] start_ea,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          irq_pend,
    input  logic          trap_in,
    input  logic          subj_done,
    input  logic          subj_branch_taken,
    input  logic          subj_status_load,
    output logic          busy,
    output logic          subj_valid,
    output logic [DW-1:0] subj_word,
    output logic          resume_valid,
    output logic          restart_valid,
    output logic          trap_valid,
    output logic [AW-1:0] evt_pc
);
    logic          word_is_exec;
    logic [AW-1:0] word_ea;

    exec_word_decode #(
        .DW(DW), .AW(AW), .OPW(OPW), .EXEC_OP(EXEC_OP)
    ) u_dec (
        .word    (mem_rdata),
        .is_exec (word_is_exec),
        .ea      (word_ea)
    );

    exec_chain_fsm #(
        .DW(DW), .AW(AW)
    ) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_valid       (start_valid),
        .start_is_exec     (start_is_exec),
        .start_pc          (start_pc),
        .start_ea          (start_ea),
        .mem_rvalid        (mem_rvalid),
        .mem_rdata         (mem_rdata),
        .word_is_exec      (word_is_exec),
        .word_ea           (word_ea),
        .irq_pend          (irq_pend),
        .trap_in           (trap_in),
        .subj_done         (subj_done),
        .subj_branch_taken (subj_branch_taken),
        .subj_status_load  (subj_status_load),
        .busy              (busy),
        .mem_req           (mem_req),
        .mem_addr          (mem_addr),
        .subj_valid        (subj_valid),
        .subj_word         (subj_word),
        .resume_valid      (resume_valid),
        .restart_valid     (restart_valid),
        .trap_valid        (trap_valid),
        .evt_pc            (evt_pc)
    );

endmodule

// File: tb/exec_chain_ctrl_bench.sv
`timescale 1ns/1ps
module exec_chain_ctrl_bench;
    localparam int DW = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic          start_is_exec = 1'b0;
    logic [AW-1:0] start_pc = '0;
    logic [AW-1:0] start_ea = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [DW-1:0] mem_rdata;
    logic          irq_pend = 1'b0;
    logic          trap_in = 1'b0;
    logic          subj_done = 1'b0;
    logic          subj_branch_taken = 1'b0;
    logic          subj_status_load = 1'b0;
    logic          busy;
    logic          subj_valid;
    logic [DW-1:0] subj_word;
    logic          resume_valid;
    logic          restart_valid;
    logic          trap_valid;
    logic [AW-1:0] evt_pc;

    logic [DW-1:0] mem [64];
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    exec_chain_ctrl u_exec_chain_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_is_exec(start_is_exec),
        .start_pc(start_pc), .start_ea(start_ea),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .irq_pend(irq_pend), .trap_in(trap_in),
        .subj_done(subj_done), .subj_branch_taken(subj_branch_taken),
        .subj_status_load(subj_status_load),
        .busy(busy), .subj_valid(subj_valid), .subj_word(subj_word),
        .resume_valid(resume_valid), .restart_valid(restart_valid),
        .trap_valid(trap_valid), .evt_pc(evt_pc)
    );

    // memory: answers one cycle after a request, response lasts one cycle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else if (mem_req && !mem_rvalid) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[5:0]];
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_events(input string req, input bit s, input bit rs,
                              input bit rt, input bit tr);
        chk(subj_valid == s,     {req, " subj_valid"},    int'(subj_valid),    int'(s));
        chk(resume_valid == rs,  {req, " resume_valid"},  int'(resume_valid),  int'(rs));
        chk(restart_valid == rt, {req, " restart_valid"}, int'(restart_valid), int'(rt));
        chk(trap_valid == tr,    {req, " trap_valid"},    int'(trap_valid),    int'(tr));
    endtask

    // fmode: 0 none, 1 trap while waiting at fetch lvl, 2 irq at response of fetch lvl
    // smode: 0 done, 1 branch, 2 status, 3 irq, 4 trap, 5 trap+irq, 6 irq+done
    task automatic run(input int d, input int smode, input int fmode,
                       input int lvl, input logic [AW-1:0] pc);
        int base;
        int nf;
        logic [DW-1:0] expw;
        base = d * 8 + 1;
        nf   = d + 1;
        expw = {((d % 2) != 0) ? 4'h3 : 4'hB, 12'(d * 16 + smode)};
        for (int i = 0; i < d; i++) mem[base + i] = {4'hA, 12'(base + i + 1)};
        mem[base + d] = expw;
        step(); step();
        start_valid = 1'b1; start_is_exec = 1'b1; start_pc = pc; start_ea = 12'(base);
        step();
        chk(busy && mem_req, "R2 start busy/req", int'({busy, mem_req}), 3);
        chk(mem_addr == 12'(base), "R2 first address", int'(mem_addr), base);
        for (int e = 1; e <= 2 * nf; e++) begin
            start_valid = (e == 1);
            start_pc    = 12'h7FF;
            start_ea    = 12'h03F;
            irq_pend    = (fmode == 2) && (e == 2 * lvl);
            trap_in     = (fmode == 1) && (e == 2 * lvl - 1);
            step();
            start_valid = 1'b0; irq_pend = 1'b0; trap_in = 1'b0;
            if (fmode == 1 && e == 2 * lvl - 1) begin
                chk_events("R8 trap in chain", 1'b0, 1'b0, 1'b0, 1'b1);
                chk(evt_pc == pc, "R8 R9 trap address", int'(evt_pc), int'(pc));
                chk(!busy, "R8 idle after trap", int'(busy), 0);
                return;
            end
            if (fmode == 2 && e == 2 * lvl) begin
                chk_events("R7 irq in chain", 1'b0, 1'b0, 1'b1, 1'b0);
                chk(evt_pc == pc, "R7 R9 restart address", int'(evt_pc), int'(pc));
                chk(!busy, "R7 idle after irq", int'(busy), 0);
                return;
            end
            if (e < 2 * nf) begin
                chk(busy && mem_req, "R3 chain busy", int'({busy, mem_req}), 3);
                chk(mem_addr == 12'(base + e / 2), "R3 chain address",
                    int'(mem_addr), base + e / 2);
                chk(!subj_valid, "R4 no early subject", int'(subj_valid), 0);
            end else begin
                chk_events("R4 dispatch", 1'b1, 1'b0, 1'b0, 1'b0);
                chk(subj_word == expw, "R4 subject word", int'(subj_word), int'(expw));
            end
        end
        step();
        chk(busy && !subj_valid && !mem_req, "R4 waiting subject",
            int'({busy, subj_valid, mem_req}), 4);
        subj_done         = (smode == 0) || (smode == 1) || (smode == 2) || (smode == 6);
        subj_branch_taken = (smode == 1);
        subj_status_load  = (smode == 2);
        irq_pend          = (smode == 3) || (smode == 5) || (smode == 6);
        trap_in           = (smode == 4) || (smode == 5);
        step();
        subj_done = 1'b0; subj_branch_taken = 1'b0; subj_status_load = 1'b0;
        irq_pend = 1'b0; trap_in = 1'b0;
        case (smode)
            0: begin
                chk_events("R5 resume", 1'b0, 1'b1, 1'b0, 1'b0);
                chk(evt_pc == pc + 12'd1, "R5 R9 resume address", int'(evt_pc), int'(pc + 12'd1));
            end
            1, 2: chk_events("R6 own next address", 1'b0, 1'b0, 1'b0, 1'b0);
            3, 6: begin
                chk_events("R7 irq in subject", 1'b0, 1'b0, 1'b1, 1'b0);
                chk(evt_pc == pc, "R7 R9 restart address", int'(evt_pc), int'(pc));
            end
            default: begin
                chk_events("R8 trap in subject", 1'b0, 1'b0, 1'b0, 1'b1);
                chk(evt_pc == pc, "R8 R9 trap address", int'(evt_pc), int'(pc));
            end
        endcase
        chk(!busy, "R5 R6 idle after subject", int'(busy), 0);
        step();
        chk_events("R10 pulse length", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        step(); step();
        chk(!busy && !mem_req, "R1 reset busy/req", int'({busy, mem_req}), 0);
        chk_events("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        chk_events("R1 after release", 1'b0, 1'b0, 1'b0, 1'b0);
        start_valid = 1'b1; start_is_exec = 1'b0; start_ea = 12'h010;
        step();
        start_valid = 1'b0;
        step();
        chk(!busy && !mem_req, "R2 non-execute start ignored", int'({busy, mem_req}), 0);
        for (int d = 0; d <= 5; d++)
            for (int s = 0; s <= 6; s++)
                run(d, s, 0, 0, 12'(d * 97 + s * 13 + 5));
        run(2, 0, 0, 0, 12'hFFF);
        for (int d = 0; d <= 4; d++)
            for (int l = 1; l <= d + 1; l++) begin
                run(d, 0, 1, l, 12'(d * 40 + l + 300));
                run(d, 0, 2, l, 12'(d * 40 + l + 600));
            end
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule